// File: doc/BRIEF.md
# Bus cycle wait-state controller

This block times a single CPU-side memory bus cycle. A request is taken only when the controller is idle. At that moment it samples the target region, the direction, the byte enables and the configuration inputs. From these it works out how many wait clocks to add to the basic one-clock cycle.

The region can be internal RAM/ROM, the special-function register area, or one of four external areas, and each external area has its own 2-bit wait setting. A global software-wait enable gates the per-area settings. Two fixed minimums still apply on the external side: a write needs at least one wait, and an access on the multiplexed bus needs at least two. The SFR area always takes two clocks.

When the DRAM controller is enabled and the access falls in the DRAM space, the block also drives active-low row and column strobes and a write strobe. These strobes follow the access size and the address parity, and they stay asserted for as long as the cycle lasts.

Top module: `bus_wait_ctrl`

## Requirements
- R1: For an external region (`region_i` = 2 or 3) with the wait enable set, a read on the plain bus lasts 1 + S clocks. S is the 2-bit setting of area A, taken from `area_wait_i[2A+1:2A]` with A = `area_i`; the other areas' settings have no effect.
- R2: An external write never finishes in one clock. If the resolved setting is 0, the write takes one wait (2 clocks).
- R3: On the multiplexed bus (`mux_bus_i`=1), an external access with a resolved setting of 0 or 1 takes two waits (3 clocks). A setting of 2 or 3 applies unchanged.
- R4: With `wait_en_i`=0, every external area behaves as if its setting were 0. The write and multiplexed-bus minimums of R2 and R3 still apply.
- R5: An internal-memory access (`region_i`=0) lasts 1 clock when `int_wait_i`=0 and 2 clocks when it is 1. The direction and the bus mode have no effect on it.
- R6: An SFR access (`region_i`=1) always lasts 2 clocks, whatever the values of `int_wait_i`, the direction and the bus mode.
- R7: `busy_o` is high from the clock after acceptance through the last clock of the cycle. `done_o` is high for exactly one clock, which is that last clock.
- R8: A request is accepted only while idle. `req_i` held high during a cycle has no effect on that cycle, and `busy_o` drops for at least one clock after `done_o`.
- R9: The configuration inputs are sampled at acceptance. Changing them during a cycle does not change that cycle's length or its strobes.
- R10: When `dram_en_i` and `dram_hit_i` are both 1 at acceptance, `ras_n_o` is low for the whole cycle. `dw_n_o` is low for a write and high for a read. Otherwise all four strobes stay high.
- R11: On a 16-bit data bus (`bus16_i`=1), `casl_n_o` is low when `ben_i[0]` (even byte) is set and `cash_n_o` is low when `ben_i[1]` (odd byte) is set. A lane that is not enabled stays high.
- R12: On an 8-bit data bus (`bus16_i`=0), `casl_n_o` is low for every DRAM access and `cash_n_o` stays high.
- R13: After reset, `busy_o` and `done_o` are low and all four strobes are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Access request, taken when idle |
| region_i | input | 2 | 0 internal memory, 1 SFR, 2 or 3 external |
| area_i | input | 2 | External area index |
| wr_i | input | 1 | 1 write, 0 read |
| ben_i | input | 2 | Byte enables: bit 0 even byte, bit 1 odd byte |
| bus16_i | input | 1 | 1 for a 16-bit data bus, 0 for 8-bit |
| mux_bus_i | input | 1 | Multiplexed external bus |
| wait_en_i | input | 1 | Global software-wait enable |
| int_wait_i | input | 1 | Internal memory wait bit |
| area_wait_i | input | 8 | Wait settings, 2 bits per external area |
| dram_en_i | input | 1 | DRAM controller enabled |
| dram_hit_i | input | 1 | Access falls in the DRAM space |
| busy_o | output | 1 | Cycle in progress |
| done_o | output | 1 | Final clock of the cycle |
| ras_n_o | output | 1 | Row strobe, active low |
| casl_n_o | output | 1 | Even/low-lane column strobe, active low |
| cash_n_o | output | 1 | Odd/high-lane column strobe, active low |
| dw_n_o | output | 1 | DRAM write strobe, active low |

## Verification
The hardest case to reach from the ports is a cycle whose sampled configuration differs from the configuration present while the cycle runs. The bench produces it by inverting every wait setting and flipping the enable, bus-mode, internal-wait and DRAM inputs on the first busy clock, then checking that the cycle length and the strobes still match the values it predicted from the accepted configuration. It also holds `req_i` high through a whole cycle to show that no request is taken until `busy_o` has dropped.

// File: rtl/bwc_pkg.sv
package bwc_pkg;

  typedef enum logic [1:0] {
    RG_INTMEM = 2'd0,
    RG_SFR    = 2'd1,
    RG_EXT    = 2'd2,
    RG_EXT2   = 2'd3
  } region_e;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_ACCESS = 2'd1,
    ST_WAIT   = 2'd2,
    ST_DONE   = 2'd3
  } state_e;

  typedef struct packed {
    logic dram;
    logic wr;
    logic lane_lo;
    logic lane_hi;
  } strobe_cfg_t;

endpackage

// File: rtl/bwc_wait_resolve.sv
module bwc_wait_resolve #(
  parameter int N_AREAS = 4,
  parameter int WAIT_W  = 2,
  localparam int AREA_W = $clog2(N_AREAS)
) (
  input  logic [1:0]              region_i,
  input  logic [AREA_W-1:0]       area_i,
  input  logic                    wr_i,
  input  logic                    mux_bus_i,
  input  logic                    wait_en_i,
  input  logic                    int_wait_i,
  input  logic [N_AREAS*WAIT_W-1:0] area_wait_i,
  output logic [WAIT_W-1:0]       waits_o
);
  import bwc_pkg::*;

  localparam logic [WAIT_W-1:0] MUX_FLOOR = WAIT_W'(2);
  localparam logic [WAIT_W-1:0] WR_FLOOR  = WAIT_W'(1);
  localparam logic [WAIT_W-1:0] SFR_WAITS = WAIT_W'(1);

  function automatic logic [WAIT_W-1:0] raise_to(input logic [WAIT_W-1:0] v,
                                                 input logic [WAIT_W-1:0] lo);
    return (v < lo) ? lo : v;
  endfunction

  logic [WAIT_W-1:0] setting_arr [N_AREAS];

  for (genvar a = 0; a < N_AREAS; a++) begin : g_area
    assign setting_arr[a] = area_wait_i[a*WAIT_W +: WAIT_W];
  end

  logic [WAIT_W-1:0] ext_sel;
  logic [WAIT_W-1:0] ext_floor;

  always_comb begin
    ext_sel   = wait_en_i ? setting_arr[area_i] : '0;
    ext_floor = mux_bus_i ? MUX_FLOOR : (wr_i ? WR_FLOOR : '0);
    case (region_e'(region_i))
      RG_INTMEM: waits_o = WAIT_W'(int_wait_i);
      RG_SFR:    waits_o = SFR_WAITS;
      default:   waits_o = raise_to(ext_sel, ext_floor);
    endcase
  end

endmodule

// File: rtl/bwc_seq.sv
module bwc_seq #(
  parameter int WAIT_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_i,
  input  logic [WAIT_W-1:0] waits_i,
  output logic              accept_o,
  output logic              busy_o,
  output logic              done_o
);
  import bwc_pkg::*;

  state_e            state_q, state_d;
  logic [WAIT_W-1:0] cnt_q, cnt_d;

  assign accept_o = req_i && (state_q == ST_IDLE);

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    case (state_q)
      ST_IDLE: begin
        if (accept_o) begin
          if (waits_i == '0) begin
            state_d = ST_DONE;
          end else begin
            state_d = ST_ACCESS;
            cnt_d   = waits_i - WAIT_W'(1);
          end
        end
      end
      ST_ACCESS, ST_WAIT: begin
        if (cnt_q == '0) begin
          state_d = ST_DONE;
        end else begin
          state_d = ST_WAIT;
          cnt_d   = cnt_q - WAIT_W'(1);
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
    end
  end

  assign busy_o = (state_q != ST_IDLE);
  assign done_o = (state_q == ST_DONE);

endmodule

// File: rtl/bwc_dram_strobe.sv
module bwc_dram_strobe (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       accept_i,
  input  logic       busy_i,
  input  logic       dram_en_i,
  input  logic       dram_hit_i,
  input  logic       wr_i,
  input  logic       bus16_i,
  input  logic [1:0] ben_i,
  output logic       ras_n_o,
  output logic       casl_n_o,
  output logic       cash_n_o,
  output logic       dw_n_o
);
  import bwc_pkg::*;

  strobe_cfg_t cfg_q, cfg_d;

  always_comb begin
    cfg_d.dram    = dram_en_i && dram_hit_i;
    cfg_d.wr      = wr_i;
    cfg_d.lane_lo = bus16_i ? ben_i[0] : 1'b1;
    cfg_d.lane_hi = bus16_i ? ben_i[1] : 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cfg_q <= '0;
    else if (accept_i) cfg_q <= cfg_d;
  end

  logic live;
  assign live     = busy_i && cfg_q.dram;
  assign ras_n_o  = !live;
  assign dw_n_o   = !(live && cfg_q.wr);
  assign casl_n_o = !(live && cfg_q.lane_lo);
  assign cash_n_o = !(live && cfg_q.lane_hi);

endmodule

// File: rtl/bus_wait_ctrl.sv
module bus_wait_ctrl #(
  parameter int N_AREAS = 4,
  parameter int WAIT_W  = 2,
  localparam int AREA_W = $clog2(N_AREAS)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      req_i,
  input  logic [1:0]                region_i,
  input  logic [AREA_W-1:0]         area_i,
  input  logic                      wr_i,
  input  logic [1:0]                ben_i,
  input  logic                      bus16_i,
  input  logic                      mux_bus_i,
  input  logic                      wait_en_i,
  input  logic                      int_wait_i,
  input  logic [N_AREAS*WAIT_W-1:0] area_wait_i,
  input  logic                      dram_en_i,
  input  logic                      dram_hit_i,
  output logic                      busy_o,
  output logic                      done_o,
  output logic                      ras_n_o,
  output logic                      casl_n_o,
  output logic                      cash_n_o,
  output logic                      dw_n_o
);

  logic [WAIT_W-1:0] waits_w;
  logic              accept_w;

  bwc_wait_resolve #(.N_AREAS(N_AREAS), .WAIT_W(WAIT_W)) resolve_i (
    .region_i   (region_i),
    .area_i     (area_i),
    .wr_i       (wr_i),
    .mux_bus_i  (mux_bus_i),
    .wait_en_i  (wait_en_i),
    .int_wait_i (int_wait_i),
    .area_wait_i(area_wait_i),
    .waits_o    (waits_w)
  );

  bwc_seq #(.WAIT_W(WAIT_W)) seq_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .req_i   (req_i),
    .waits_i (waits_w),
    .accept_o(accept_w),
    .busy_o  (busy_o),
    .done_o  (done_o)
  );

  bwc_dram_strobe strobe_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .accept_i  (accept_w),
    .busy_i    (busy_o),
    .dram_en_i (dram_en_i),
    .dram_hit_i(dram_hit_i),
    .wr_i      (wr_i),
    .bus16_i   (bus16_i),
    .ben_i     (ben_i),
    .ras_n_o   (ras_n_o),
    .casl_n_o  (casl_n_o),
    .cash_n_o  (cash_n_o),
    .dw_n_o    (dw_n_o)
  );

endmodule

// File: rtl/bus_wait_ctrl_chk.sv
module bus_wait_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       accept_w,
  input logic [1:0] region_i,
  input logic       busy_o,
  input logic       done_o,
  input logic       ras_n_o,
  input logic       casl_n_o,
  input logic       cash_n_o,
  input logic       dw_n_o
);

  p_done_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  p_done_in_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> busy_o);

  p_accept_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    accept_w |-> !busy_o);

  p_gap_after_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !busy_o);

  p_sfr_two_clk_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (accept_w && region_i == bwc_pkg::RG_SFR) |=> (busy_o && !done_o) ##1 done_o);

  p_ras_in_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !ras_n_o |-> busy_o);

  p_dw_with_ras_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !dw_n_o |-> !ras_n_o);

  p_cas_with_ras_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!casl_n_o || !cash_n_o) |-> !ras_n_o);

endmodule

bind bus_wait_ctrl bus_wait_ctrl_chk chk_i (
  .clk     (clk),
  .rst_n   (rst_n),
  .accept_w(accept_w),
  .region_i(region_i),
  .busy_o  (busy_o),
  .done_o  (done_o),
  .ras_n_o (ras_n_o),
  .casl_n_o(casl_n_o),
  .cash_n_o(cash_n_o),
  .dw_n_o  (dw_n_o)
);

// File: tb/bus_wait_ctrl_tb_top.sv
`timescale 1ns/1ps
module bus_wait_ctrl_tb_top;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       req_i = 1'b0;
  logic [1:0] region_i = 2'd0;
  logic [1:0] area_i = 2'd0;
  logic       wr_i = 1'b0;
  logic [1:0] ben_i = 2'b11;
  logic       bus16_i = 1'b1;
  logic       mux_bus_i = 1'b0;
  logic       wait_en_i = 1'b1;
  logic       int_wait_i = 1'b0;
  logic [7:0] area_wait_i = 8'h00;
  logic       dram_en_i = 1'b0;
  logic       dram_hit_i = 1'b0;
  logic       busy_o, done_o, ras_n_o, casl_n_o, cash_n_o, dw_n_o;

  int checks = 0;
  int errors = 0;
  logic e_ras = 1, e_casl = 1, e_cash = 1, e_dw = 1;

  always #2 clk = ~clk;

  bus_wait_ctrl dut_i (.*);

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int ext_len(input int val, input bit wr, input bit mux, input bit en);
    int w;
    w = en ? val : 0;
    if (wr && w < 1) w = 1;
    if (mux && w < 2) w = 2;
    return w + 1;
  endfunction

  function automatic logic [7:0] pattern(input int area, input int val);
    logic [7:0] p;
    for (int a = 0; a < 4; a++) p[a*2 +: 2] = (a == area) ? 2'(val) : 2'(3 - val);
    return p;
  endfunction

  task automatic check_strobes(input string req);
    chk(ras_n_o == e_ras && dw_n_o == e_dw, req, "ras/dw",
        {ras_n_o, dw_n_o}, {e_ras, e_dw});
    chk(casl_n_o == e_casl && cash_n_o == e_cash, req, "casl/cash",
        {casl_n_o, cash_n_o}, {e_casl, e_cash});
  endtask

  // Called at a negedge while idle. Runs one access of exp_n clocks.
  task automatic run_access(input int exp_n, input string req, input bit perturb, input bit hold);
    logic [7:0] sv_aw;
    logic sv_en, sv_mux, sv_iw, sv_de, sv_dh, sv_b16;
    logic [1:0] sv_ben;
    req_i = 1'b1;
    for (int k = 1; k <= exp_n; k++) begin
      @(negedge clk);
      if (!hold) req_i = 1'b0;
      chk(busy_o == 1'b1, req, $sformatf("busy at clock %0d", k), busy_o, 1);
      chk(done_o == (k == exp_n), req, $sformatf("done at clock %0d", k), done_o, (k == exp_n));
      check_strobes(req);
      if (perturb && k == 1) begin
        sv_aw = area_wait_i; sv_en = wait_en_i; sv_mux = mux_bus_i; sv_iw = int_wait_i;
        sv_de = dram_en_i; sv_dh = dram_hit_i; sv_b16 = bus16_i; sv_ben = ben_i;
        area_wait_i = ~area_wait_i; wait_en_i = ~wait_en_i; mux_bus_i = ~mux_bus_i;
        int_wait_i = ~int_wait_i; dram_en_i = ~dram_en_i; dram_hit_i = ~dram_hit_i;
        bus16_i = ~bus16_i; ben_i = ~ben_i;
      end
    end
    @(negedge clk);
    req_i = 1'b0;
    chk(busy_o == 1'b0 && done_o == 1'b0, "R8", {req, " idle gap after done"}, {busy_o, done_o}, 0);
    chk(ras_n_o && casl_n_o && cash_n_o && dw_n_o, "R10", "strobes high when idle",
        {ras_n_o, casl_n_o, cash_n_o, dw_n_o}, 15);
    if (perturb) begin
      area_wait_i = sv_aw; wait_en_i = sv_en; mux_bus_i = sv_mux; int_wait_i = sv_iw;
      dram_en_i = sv_de; dram_hit_i = sv_dh; bus16_i = sv_b16; ben_i = sv_ben;
    end
  endtask

  task automatic run_all();
    // R13 reset state
    #5;
    chk(busy_o == 0 && done_o == 0, "R13", "busy/done in reset", {busy_o, done_o}, 0);
    chk(ras_n_o && casl_n_o && cash_n_o && dw_n_o, "R13", "strobes in reset",
        {ras_n_o, casl_n_o, cash_n_o, dw_n_o}, 15);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    chk(busy_o == 0 && done_o == 0, "R13", "idle after reset", {busy_o, done_o}, 0);

    // External sweep: R1, R2, R3, R4
    for (int area = 0; area < 4; area++)
      for (int val = 0; val < 4; val++)
        for (int wr = 0; wr < 2; wr++)
          for (int mux = 0; mux < 2; mux++)
            for (int en = 0; en < 2; en++) begin
              region_i = 2'(2 + (area & 1));
              area_i = 2'(area); wr_i = wr[0]; mux_bus_i = mux[0]; wait_en_i = en[0];
              area_wait_i = pattern(area, val);
              run_access(ext_len(val, wr[0], mux[0], en[0]),
                         !en ? "R4" : (mux ? "R3" : (wr ? "R2" : "R1")), 1'b0, 1'b0);
            end

    // Internal memory R5 and SFR R6
    for (int iw = 0; iw < 2; iw++)
      for (int wr = 0; wr < 2; wr++)
        for (int mux = 0; mux < 2; mux++) begin
          wr_i = wr[0]; mux_bus_i = mux[0]; int_wait_i = iw[0]; wait_en_i = 1'b1;
          area_wait_i = 8'hFF;
          region_i = 2'd0;
          run_access(1 + iw, "R5", 1'b0, 1'b0);
          region_i = 2'd1;
          run_access(2, "R6", 1'b0, 1'b0);
        end

    // R9: configuration changes during the cycle
    region_i = 2'd2; area_i = 2'd1; wr_i = 0; mux_bus_i = 0; wait_en_i = 1;
    area_wait_i = pattern(1, 3);
    run_access(4, "R9", 1'b1, 1'b0);
    area_wait_i = pattern(1, 0);
    run_access(1, "R9", 1'b1, 1'b0);
    region_i = 2'd0; int_wait_i = 0;
    run_access(1, "R9", 1'b1, 1'b0);

    // R8: request held high through the cycle
    region_i = 2'd3; area_i = 2'd2; wait_en_i = 1; area_wait_i = pattern(2, 2);
    run_access(3, "R8", 1'b0, 1'b1);
    region_i = 2'd1;
    run_access(2, "R8", 1'b0, 1'b1);

    // DRAM strobes R10, R11, R12
    region_i = 2'd2; area_i = 2'd0; mux_bus_i = 0; wait_en_i = 1; area_wait_i = pattern(0, 1);
    for (int b16 = 0; b16 < 2; b16++)
      for (int be = 1; be < 4; be++)
        for (int wr = 0; wr < 2; wr++) begin
          bus16_i = b16[0]; ben_i = 2'(be); wr_i = wr[0];
          dram_en_i = 1; dram_hit_i = 1;
          e_ras = 0; e_dw = !wr[0];
          e_casl = b16 ? !be[0] : 1'b0;
          e_cash = b16 ? !be[1] : 1'b1;
          run_access(2, b16 ? "R11" : "R12", 1'b0, 1'b0);
        end
    // R9 on strobes: DRAM inputs flipped mid-cycle
    bus16_i = 1; ben_i = 2'b01; wr_i = 1;
    e_ras = 0; e_dw = 0; e_casl = 0; e_cash = 1;
    run_access(2, "R9", 1'b1, 1'b0);
    // R10: no DRAM strobes unless both enable and hit
    for (int c = 0; c < 3; c++) begin
      dram_en_i = (c != 0); dram_hit_i = (c != 1); wr_i = 1; ben_i = 2'b11;
      e_ras = (c == 2) ? 0 : 1; e_dw = e_ras; e_casl = e_ras; e_cash = e_ras;
      run_access(2, "R10", 1'b0, 1'b0);
    end
    e_ras = 1; e_dw = 1; e_casl = 1; e_cash = 1;
    dram_en_i = 0;
  endtask

  initial begin
    fork
      run_all();
      begin
        repeat (150000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule